// File: doc/BRIEF.md
# Multi-Way Sequential Stream Prefetcher

This block sits next to a cache. It keeps a few small FIFO stream buffers, and each one holds a run of consecutive line addresses along with the data fetched for them. When the cache misses, it sends the byte address here.

The block compares that address against the head entry of every buffer. If a head matches and its data is present, the block answers with a hit and the data. The buffer then moves up one slot, and the freed tail slot takes the next sequential line. If a head matches but its data has not arrived yet, the lookup stalls until the fill lands.

If no head matches, the block answers with a miss. It then clears the least recently used buffer and restarts it at the line after the missing one.

Line fetches go to next-level memory one per cycle through a valid/ready request port, taking the buffers in round-robin order. Fills come back tagged with their line address and are accepted without back-pressure.

Top module: `stream_prefetcher`

## Requirements
- R1: A line address is the byte address shifted right by LINE_SHIFT (6, for 64-byte lines). Requests and fills carry line addresses, so byte offsets inside a line do not affect matching.
- R2: A lookup that matches no buffer head gives resp_valid=1 with resp_hit=0 in the cycle after acceptance. The least recently used buffer is reloaded with lines L+1 to L+DEPTH, where L is the missing line, and these are requested in ascending order.
- R3: A lookup whose matching head already holds data gives resp_valid=1 and resp_hit=1 in the cycle after acceptance, with resp_data equal to that line's fill data.
- R4: A head hit shifts its buffer up by one entry. The tail then requests the line that follows the buffer's last line, so consuming line L+1 requests L+DEPTH+1.
- R5: Only head entries are compared. An address that matches a deeper entry counts as a miss and causes a reallocation.
- R6: A lookup whose matching head has no data yet drops miss_ready and gives no response until the fill arrives. It then answers resp_hit=1 with the filled data.
- R7: A buffer becomes most recently used when it hits or is allocated. After reset, the buffers are allocated in index order 0, 1, 2, 3.
- R8: Buffers that hold unrequested entries share the request port in round-robin order. Within a buffer, the oldest unrequested entry goes first.
- R9: While mem_req_valid is high and mem_req_ready is low, the request stays valid with the same line in the next cycle. The exception is a cycle in which a lookup response is produced.
- R10: After reset, miss_ready=1, resp_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss lookup request |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_ready | output | 1 | Lookup can be accepted |
| resp_valid | output | 1 | Lookup answer is present |
| resp_hit | output | 1 | Answer is a stream-buffer hit |
| resp_data | output | DATA_W | Line data for a hit |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | ADDR_W-LINE_SHIFT | Line address to fetch |
| mem_rsp_valid | input | 1 | Fill returned |
| mem_rsp_line | input | ADDR_W-LINE_SHIFT | Line address of the fill |
| mem_rsp_data | input | DATA_W | Fill data |

## Verification
The hardest situations to reach are a head hit on a line that is still in flight, and an eviction decision that depends on recent use. The bench raises the memory latency and looks up line L+1 right after the miss on L, so it lands on a pending head.

For replacement, the bench opens four streams, touches one of them, and forces one more allocation. It then probes every stream to see which one was lost.

Round-robin order is exposed by holding mem_req_ready low while two buffers fill up, then releasing it and reading the request sequence.

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int NBUF       = 4,
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 6,
  parameter int DATA_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         miss_valid,
  input  logic [ADDR_W-1:0]            miss_addr,
  output logic                         miss_ready,
  output logic                         resp_valid,
  output logic                         resp_hit,
  output logic [DATA_W-1:0]            resp_data,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [ADDR_W-LINE_SHIFT-1:0] mem_req_line,
  input  logic                         mem_rsp_valid,
  input  logic [ADDR_W-LINE_SHIFT-1:0] mem_rsp_line,
  input  logic [DATA_W-1:0]            mem_rsp_data
);
  localparam int LW = ADDR_W - LINE_SHIFT;
  localparam int BW = $clog2(NBUF);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic              vld;
    logic              req;
    logic              rdy;
    logic [LW-1:0]     tag;
    logic [DATA_W-1:0] data;
  } ent_t;

  ent_t        ent [NBUF][DEPTH];
  ent_t        nxt [NBUF][DEPTH];
  logic [BW-1:0] age [NBUF];
  logic [BW-1:0] ptr, wbuf, hit_b, lru_b, gnt_b, sh_b, tch_b;
  logic [SW-1:0] pslot [NBUF];
  logic [NBUF-1:0] pend;
  logic          waiting, hit_any, gnt_any;
  logic          accept, do_hit, do_wait, do_alloc, wake, sh_en, tch_en;
  logic [LW-1:0] miss_line;

  assign miss_line  = miss_addr[ADDR_W-1:LINE_SHIFT];
  assign miss_ready = !waiting;
  assign accept     = miss_valid && !waiting;

  always_comb begin
    hit_any = 1'b0;
    hit_b   = '0;
    lru_b   = '0;
    for (int b = NBUF-1; b >= 0; b--) begin
      if (ent[b][0].vld && ent[b][0].tag == miss_line) begin
        hit_any = 1'b1;
        hit_b   = BW'(b);
      end
      if (age[b] == BW'(NBUF-1)) lru_b = BW'(b);
    end
  end

  always_comb begin
    for (int b = 0; b < NBUF; b++) begin
      pend[b]  = 1'b0;
      pslot[b] = '0;
      for (int s = DEPTH-1; s >= 0; s--)
        if (ent[b][s].vld && !ent[b][s].req) begin
          pend[b]  = 1'b1;
          pslot[b] = SW'(s);
        end
    end
    gnt_any = 1'b0;
    gnt_b   = '0;
    for (int k = NBUF-1; k >= 0; k--)
      if (pend[(int'(ptr) + k) % NBUF]) begin
        gnt_any = 1'b1;
        gnt_b   = BW'((int'(ptr) + k) % NBUF);
      end
  end

  assign mem_req_valid = gnt_any;
  assign mem_req_line  = ent[gnt_b][pslot[gnt_b]].tag;

  assign do_hit   = accept && hit_any && ent[hit_b][0].rdy;
  assign do_wait  = accept && hit_any && !ent[hit_b][0].rdy;
  assign do_alloc = accept && !hit_any;
  assign wake     = waiting && ent[wbuf][0].rdy;
  assign sh_en    = do_hit || wake;
  assign sh_b     = wake ? wbuf : hit_b;
  assign tch_en   = do_hit || do_wait || do_alloc;
  assign tch_b    = do_alloc ? lru_b : hit_b;

  always_comb begin
    nxt = ent;
    if (mem_rsp_valid)
      for (int b = 0; b < NBUF; b++)
        for (int s = 0; s < DEPTH; s++)
          if (ent[b][s].vld && ent[b][s].req && !ent[b][s].rdy && ent[b][s].tag == mem_rsp_line) begin
            nxt[b][s].rdy  = 1'b1;
            nxt[b][s].data = mem_rsp_data;
          end
    if (gnt_any && mem_req_ready) nxt[gnt_b][pslot[gnt_b]].req = 1'b1;
    if (sh_en) begin
      for (int s = 0; s < DEPTH-1; s++) nxt[sh_b][s] = nxt[sh_b][s+1];
      nxt[sh_b][DEPTH-1] = '{vld: 1'b1, req: 1'b0, rdy: 1'b0,
                             tag: ent[sh_b][DEPTH-1].tag + LW'(1), data: '0};
    end
    if (do_alloc)
      for (int s = 0; s < DEPTH; s++)
        nxt[lru_b][s] = '{vld: 1'b1, req: 1'b0, rdy: 1'b0,
                          tag: miss_line + LW'(s + 1), data: '0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBUF; b++) begin
        for (int s = 0; s < DEPTH; s++) ent[b][s] <= '0;
        age[b] <= BW'(NBUF - 1 - b);
      end
      waiting    <= 1'b0;
      wbuf       <= '0;
      ptr        <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      ent        <= nxt;
      resp_valid <= do_hit || do_alloc || wake;
      resp_hit   <= do_hit || wake;
      resp_data  <= wake ? ent[wbuf][0].data : do_hit ? ent[hit_b][0].data : '0;
      if (do_wait) begin
        waiting <= 1'b1;
        wbuf    <= hit_b;
      end else if (wake) begin
        waiting <= 1'b0;
      end
      if (gnt_any && mem_req_ready) ptr <= BW'((int'(gnt_b) + 1) % NBUF);
      if (tch_en)
        for (int b = 0; b < NBUF; b++)
          if (BW'(b) == tch_b) age[b] <= '0;
          else if (age[b] < age[tch_b]) age[b] <= age[b] + BW'(1);
    end
  end
endmodule

// File: rtl/prefetch_checks.sv
module prefetch_checks #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 6,
  parameter int DATA_W     = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         miss_valid,
  input logic                         miss_ready,
  input logic                         resp_valid,
  input logic                         resp_hit,
  input logic                         mem_req_valid,
  input logic                         mem_req_ready,
  input logic [ADDR_W-LINE_SHIFT-1:0] mem_req_line
);
  assert_miss_prompt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $past(miss_valid && miss_ready));

  assert_answer_or_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (resp_valid || !miss_ready));

  assert_stall_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(miss_ready) |-> $past(miss_valid));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (resp_valid || (mem_req_valid && $stable(mem_req_line))));
endmodule

bind stream_prefetcher prefetch_checks #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_ready, resp_valid, resp_hit, mem_req_valid, mem_req_ready;
  logic [31:0] resp_data;
  logic [25:0] mem_req_line;
  logic        mem_rsp_valid = 1'b0;
  logic [25:0] mem_rsp_line = '0;
  logic [31:0] mem_rsp_data = '0;
  logic        rdy_en = 1'b1;
  int          lat = 3;
  int          cyc = 0;
  int          total = 0, bad = 0;
  logic [25:0] reqlog [256];
  int          nreq = 0;
  logic [25:0] qline [$];
  int          qdue [$];

  always #2.5 clk = ~clk;
  assign mem_req_ready = rdy_en;

  stream_prefetcher u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line), .mem_rsp_data(mem_rsp_data));

  function automatic logic [31:0] fd(input logic [25:0] l);
    return ({6'b0, l} * 32'h9E37) ^ 32'h5A5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      nreq = 0;
      qline.delete();
      qdue.delete();
      mem_rsp_valid <= 1'b0;
    end else begin
      if (qline.size() > 0 && qdue[0] <= cyc) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_line  <= qline[0];
        mem_rsp_data  <= fd(qline[0]);
        void'(qline.pop_front());
        void'(qdue.pop_front());
      end else mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        qline.push_back(mem_req_line);
        qdue.push_back(cyc + lat);
        if (nreq < 256) reqlog[nreq] = mem_req_line;
        nreq++;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; miss_valid = 1'b0; rdy_en = 1'b1; lat = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lookup(input logic [25:0] line, input logic [5:0] off,
                        output logic h, output logic [31:0] d, output logic st);
    int t;
    st = 1'b0;
    @(negedge clk);
    t = 0;
    while (!miss_ready && t < 1000) begin @(negedge clk); t++; end
    miss_valid = 1'b1; miss_addr = {line, off};
    @(negedge clk);
    miss_valid = 1'b0;
    t = 0;
    while (!resp_valid && t < 1000) begin
      if (!miss_ready) st = 1'b1;
      @(negedge clk); t++;
    end
    h = resp_hit; d = resp_data;
    if (t >= 1000) chk(1'b0, "lookup timeout", 32'(t), 0);
  endtask

  logic        h, st;
  logic [31:0] d;

  initial begin
    do_reset();
    chk(miss_ready === 1'b1, "R10 miss_ready", 32'(miss_ready), 1);
    chk(resp_valid === 1'b0, "R10 resp_valid", 32'(resp_valid), 0);
    chk(mem_req_valid === 1'b0, "R10 mem_req_valid", 32'(mem_req_valid), 0);

    // R1 R2 R3 R4: one stream swept
    lookup(26'h40, 6'h11, h, d, st);
    chk(h === 1'b0, "R2 first lookup miss", 32'(h), 0);
    idle(20);
    chk(nreq == 4, "R2 request count", 32'(nreq), 4);
    for (int k = 0; k < 4; k++)
      chk(reqlog[k] == 26'h41 + 26'(k), "R1 R2 prefill line", 32'(reqlog[k]), 32'(26'h41 + 26'(k)));
    for (int k = 1; k <= 8; k++) begin
      lookup(26'h40 + 26'(k), 6'(k * 7), h, d, st);
      chk(h === 1'b1, "R3 sequential hit", 32'(h), 1);
      chk(d == fd(26'h40 + 26'(k)), "R3 hit data", d, fd(26'h40 + 26'(k)));
      idle(8);
    end
    chk(nreq == 12, "R4 refill count", 32'(nreq), 12);
    for (int k = 1; k <= 8; k++)
      chk(reqlog[3 + k] == 26'h44 + 26'(k), "R4 tail refill line", 32'(reqlog[3 + k]), 32'(26'h44 + 26'(k)));

    // R5: non-head match
    do_reset();
    lookup(26'h100, 6'h0, h, d, st);
    idle(20);
    lookup(26'h102, 6'h0, h, d, st);
    chk(h === 1'b0, "R5 deeper entry is miss", 32'(h), 0);
    idle(20);
    lookup(26'h101, 6'h0, h, d, st);
    chk(h === 1'b1, "R5 original head still hits", 32'(h), 1);
    lookup(26'h103, 6'h0, h, d, st);
    chk(h === 1'b1 && d == fd(26'h103), "R5 new stream head", d, fd(26'h103));

    // R6: hit on pending head
    do_reset();
    lat = 30;
    lookup(26'h200, 6'h0, h, d, st);
    lookup(26'h201, 6'h4, h, d, st);
    chk(st === 1'b1, "R6 stalled", 32'(st), 1);
    chk(h === 1'b1, "R6 hit after fill", 32'(h), 1);
    chk(d == fd(26'h201), "R6 data", d, fd(26'h201));

    // R7: LRU replacement
    do_reset();
    for (int k = 1; k <= 4; k++) lookup(26'(k * 26'h1000), 6'h0, h, d, st);
    idle(40);
    lookup(26'h1001, 6'h0, h, d, st);
    chk(h === 1'b1, "R7 touch stream A", 32'(h), 1);
    lookup(26'h5000, 6'h0, h, d, st);
    chk(h === 1'b0, "R7 new stream miss", 32'(h), 0);
    idle(20);
    lookup(26'h3001, 6'h0, h, d, st);
    chk(h === 1'b1, "R7 stream C kept", 32'(h), 1);
    lookup(26'h4001, 6'h0, h, d, st);
    chk(h === 1'b1, "R7 stream D kept", 32'(h), 1);
    lookup(26'h1002, 6'h0, h, d, st);
    chk(h === 1'b1, "R7 stream A kept", 32'(h), 1);
    lookup(26'h5001, 6'h0, h, d, st);
    chk(h === 1'b1, "R7 stream E present", 32'(h), 1);
    lookup(26'h2001, 6'h0, h, d, st);
    chk(h === 1'b0, "R7 stream B evicted", 32'(h), 0);

    // R8 R9: round robin and hold under back-pressure
    do_reset();
    rdy_en = 1'b0;
    lookup(26'h500, 6'h0, h, d, st);
    lookup(26'h900, 6'h0, h, d, st);
    idle(2);
    chk(mem_req_valid === 1'b1 && mem_req_line == 26'h501, "R9 held request", 32'(mem_req_line), 32'h501);
    idle(3);
    chk(mem_req_valid === 1'b1 && mem_req_line == 26'h501, "R9 still held", 32'(mem_req_line), 32'h501);
    chk(nreq == 0, "R9 nothing issued", 32'(nreq), 0);
    rdy_en = 1'b1;
    idle(20);
    chk(nreq == 8, "R8 request count", 32'(nreq), 8);
    for (int k = 0; k < 8; k++) begin
      logic [25:0] e;
      e = ((k % 2) == 0 ? 26'h500 : 26'h900) + 26'(k / 2 + 1);
      chk(reqlog[k] == e, "R8 round robin order", 32'(reqlog[k]), 32'(e));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    chk(1'b0, "watchdog", 32'(cyc), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule